// File: doc/BRIEF.md
# AC-Coupled Boundary-Scan Pulse Driver Cell

This block is one boundary-scan output cell paired with a digital test receiver, built for checking interconnects that pass through a series capacitor. A static test level does not cross a capacitor, so in the two AC test classes the driver adds edges. In the pulse class it adds one inverted excursion when the TAP enters Run-Test/Idle. In the train class it adds a counted burst of toggles. In both classes the pin always comes to rest at the intended test value. The DC test class holds the test value steadily. When no test class is selected, the cell is transparent and passes the mission data to the pin.

The test value is loaded from the update-stage bit whenever the TAP signals Update-DR. On the receive side, the digitized pin input passes through a synchronizer. In the AC classes, the captured level changes only on a transition that the receiver accepts as valid: the new level must be seen for a set number of consecutive samples. A rising transition captures 1 and a falling one captures 0. When no valid transition arrives, the last captured level is kept. In the DC and transparent classes, the captured level follows the sampled input.

Top module: `acbs_pulse_cell`

## Requirements
- R1: During synchronous reset (`rst_i`=1) and on the first cycle after it, `rx_level_o` is 0 and the cell is transparent: `pin_o` equals `mission_i`.
- R2: The class register loads `cls_i` on every clock. While it holds class 0 (off), `pin_o` follows `mission_i` combinationally in the same cycle.
- R3: An edge with `upd_dr_i`=1 loads `upd_bit_i` as the test value. Under class 1 (DC), `pin_o` equals the test value on every cycle after that edge, including through Run-Test/Idle, and no edges are added.
- R4: Under class 2 (pulse), the clock edge at which `rti_i` first goes high drives `pin_o` to the inverse of the test value. The next edge returns it to the test value. This happens even when the test value did not change.
- R5: Under class 3 (train), `pin_o` goes to the inverse of the test value on entry to Run-Test/Idle. It then toggles on each clock while `rti_i` stays high, for TRAIN_LEN toggles in all (TRAIN_LEN even). After that it holds the test value.
- R6: Under class 3, the first edge with `rti_i` low drives `pin_o` to the test value, even if the train was cut short.
- R7: `pin_raw_i` reaches the receiver after SYNC_STAGES clocks. In the DC and off classes, `rx_level_o` follows the synchronized level, so it changes SYNC_STAGES+1 edges after `pin_raw_i` changes.
- R8: In the AC classes, `rx_level_o` takes a new synchronized level only after that level has been seen for HOLD consecutive samples: 1 after a rise, 0 after a fall. Shorter excursions leave `rx_level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cls_i | input | 2 | Instruction class: 0 off, 1 DC, 2 pulse, 3 train |
| upd_dr_i | input | 1 | TAP is in Update-DR |
| upd_bit_i | input | 1 | Update-stage data bit |
| rti_i | input | 1 | TAP is in Run-Test/Idle |
| mission_i | input | 1 | Mission data from the core |
| pin_raw_i | input | 1 | Digitized level seen at the pin |
| pin_o | output | 1 | Value driven toward the pin |
| rx_level_o | output | 1 | Level captured by the test receiver |

## Verification
The bench builds the cell with TRAIN_LEN=4, SYNC_STAGES=2 and HOLD=3. A train of four toggles fits into a short stay in Run-Test/Idle, so both the full burst and an exit partway through are covered. HOLD=3 allows a two-sample glitch, which must be rejected, and a three-sample level, which must be accepted, to run within a few clocks. Two synchronizer stages give a latency that can be counted edge by edge.

// File: rtl/acbs_pkg.sv
package acbs_pkg;
    typedef enum logic [1:0] {
        CLS_OFF   = 2'd0,
        CLS_DC    = 2'd1,
        CLS_PULSE = 2'd2,
        CLS_TRAIN = 2'd3
    } tclass_e;
endpackage

// File: rtl/acbs_drv.sv
module acbs_drv
    import acbs_pkg::*;
#(
    parameter int TRAIN_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cls_i,
    input  logic       upd_i,
    input  logic       bit_i,
    input  logic       rti_i,
    output logic       drv_o
);
    localparam int CW = $clog2(TRAIN_LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(TRAIN_LEN);

    typedef struct packed {
        logic          test;
        logic          drv;
        logic          rti;
        logic [CW-1:0] cnt;
    } drv_st_t;

    drv_st_t st_d, st_q;
    logic    tval;
    logic    entry;

    initial begin
        if (TRAIN_LEN < 2 || (TRAIN_LEN % 2) != 0)
            $error("TRAIN_LEN must be even and at least 2");
    end

    always_comb begin
        st_d      = st_q;
        tval      = upd_i ? bit_i : st_q.test;
        entry     = rti_i && !st_q.rti;
        st_d.test = tval;
        st_d.rti  = rti_i;
        st_d.drv  = tval;
        st_d.cnt  = '0;
        case (tclass_e'(cls_i))
            CLS_PULSE: begin
                if (entry) st_d.drv = ~tval;
            end
            CLS_TRAIN: begin
                st_d.cnt = st_q.cnt;
                if (entry) begin
                    st_d.drv = ~tval;
                    st_d.cnt = CW'(1);
                end else if (rti_i && st_q.cnt < LEN_C) begin
                    st_d.drv = ~st_q.drv;
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: st_d.drv = tval;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign drv_o = st_q.drv;

    AST_PULSE_INVERT: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_PULSE && rti_i && !st_q.rti) |=> (st_q.drv != st_q.test)); // R4
    AST_PULSE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_PULSE && rti_i && st_q.rti) |=> (st_q.drv == st_q.test)); // R4
    AST_TRAIN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_TRAIN && rti_i && st_q.rti && st_q.cnt < LEN_C) |=> (st_q.drv != $past(st_q.drv))); // R5
    AST_TRAIN_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_TRAIN && !rti_i) |=> (st_q.drv == st_q.test)); // R6
    AST_DC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cls_i == CLS_DC) |=> (st_q.drv == st_q.test)); // R3
endmodule

// File: rtl/acbs_rx.sv
module acbs_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic ac_i,
    output logic level_o
);
    localparam int RW = $clog2(HOLD + 1);
    localparam logic [RW-1:0] HOLD_C = RW'(HOLD);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic [RW-1:0]          run;
        logic                   level;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   smp;

    assign smp = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = raw_i;
        for (int i = 1; i < SYNC_STAGES; i++) st_d.sync[i] = st_q.sync[i-1];
        st_d.last = smp;
        if (smp != st_q.last)      st_d.run = RW'(1);
        else if (st_q.run < HOLD_C) st_d.run = st_q.run + RW'(1);
        if (!ac_i)                                     st_d.level = smp;
        else if (st_d.run == HOLD_C && smp != st_q.level) st_d.level = smp;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level_o = st_q.level;

    generate
        if (HOLD > 1) begin : g_glitch_chk
            AST_RX_NO_SNAP: assert property (@(posedge clk) disable iff (rst)
                (ac_i && smp != st_q.last) |=> $stable(st_q.level)); // R8
        end
    endgenerate
endmodule

// File: rtl/acbs_pulse_cell.sv
module acbs_pulse_cell
    import acbs_pkg::*;
#(
    parameter int TRAIN_LEN   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 2
) (
    input  logic       tck_i,
    input  logic       rst_i,
    input  logic [1:0] cls_i,
    input  logic       upd_dr_i,
    input  logic       upd_bit_i,
    input  logic       rti_i,
    input  logic       mission_i,
    input  logic       pin_raw_i,
    output logic       pin_o,
    output logic       rx_level_o
);
    logic [1:0] cls_d, cls_q;
    logic       drv;
    logic       ac_mode;

    always_comb cls_d = cls_i;

    always_ff @(posedge tck_i) begin
        if (rst_i) cls_q <= CLS_OFF;
        else       cls_q <= cls_d;
    end

    assign ac_mode = (cls_q == CLS_PULSE) || (cls_q == CLS_TRAIN);

    acbs_drv #(.TRAIN_LEN(TRAIN_LEN)) u_drv (
        .clk(tck_i), .rst(rst_i), .cls_i(cls_i), .upd_i(upd_dr_i),
        .bit_i(upd_bit_i), .rti_i(rti_i), .drv_o(drv)
    );

    acbs_rx #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_rx (
        .clk(tck_i), .rst(rst_i), .raw_i(pin_raw_i), .ac_i(ac_mode),
        .level_o(rx_level_o)
    );

    assign pin_o = (cls_q == CLS_OFF) ? mission_i : drv;

    AST_RESET_TRANSPARENT: assert property (@(posedge tck_i)
        rst_i |=> (cls_q == CLS_OFF && !rx_level_o)); // R1
endmodule

// File: tb/acbs_pulse_cell_test.sv
module acbs_pulse_cell_test;
    localparam int TL = 4;
    localparam int SY = 2;
    localparam int HD = 3;

    logic tck = 0, rst = 1;
    logic [1:0] cls = 0;
    logic upd = 0, ubit = 0, rti = 0, mis = 0, raw = 0;
    logic pin, rxl;

    int total = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_mode, m_test, m_drv, m_rtip, m_cnt, m_last, m_run, m_rx;
    int m_sync[SY];

    always #2.5 tck = ~tck;

    acbs_pulse_cell #(.TRAIN_LEN(TL), .SYNC_STAGES(SY), .HOLD(HD)) uut (
        .tck_i(tck), .rst_i(rst), .cls_i(cls), .upd_dr_i(upd), .upd_bit_i(ubit),
        .rti_i(rti), .mission_i(mis), .pin_raw_i(raw), .pin_o(pin), .rx_level_o(rxl)
    );

    always @(posedge tck) begin
        int t, s, nd, nc, nr, nrx;
        if (rst) begin
            m_mode = 0; m_test = 0; m_drv = 0; m_rtip = 0; m_cnt = 0;
            m_last = 0; m_run = 0; m_rx = 0;
            foreach (m_sync[i]) m_sync[i] = 0;
        end else begin
            t = upd ? int'(ubit) : m_test;
            nd = t; nc = 0;
            if (cls == 2 && rti && !m_rtip) nd = 1 - t;
            if (cls == 3) begin
                nc = m_cnt;
                if (rti && !m_rtip) begin nd = 1 - t; nc = 1; end
                else if (rti && m_cnt < TL) begin nd = 1 - m_drv; nc = m_cnt + 1; end
            end
            s  = m_sync[SY-1];
            nr = (s == m_last) ? ((m_run < HD) ? m_run + 1 : HD) : 1;
            nrx = m_rx;
            if (m_mode < 2) nrx = s;
            else if (nr == HD) nrx = s;
            m_run = nr; m_last = s; m_rx = nrx;
            for (int i = SY - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = raw;
            m_test = t; m_drv = nd; m_cnt = nc; m_rtip = rti; m_mode = cls;
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge tck); @(negedge tck);
        chk({tag, " pin"}, pin, (m_mode == 0) ? int'(mis) : m_drv);
        chk({tag, " rx"}, rxl, m_rx);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge tck); mis = 1;
        tick(); tick();
        chk("R1 reset rx", rxl, 0);
        chk("R1 reset transparent", pin, 1);
        rst = 0;
        tick();
        chk("R1 after reset", pin, int'(mis));
        // R2 transparent, combinational
        tag = "R2";
        mis = 0; #1 chk("R2 comb pass", pin, 0);
        mis = 1; #1 chk("R2 comb pass", pin, 1);
        tick();
        // R3 DC class holds test value
        tag = "R3";
        cls = 1; ubit = 1; upd = 1; tick(); upd = 0; ubit = 0;
        tick(); chk("R3 dc level", pin, 1);
        rti = 1; repeat (3) begin tick(); chk("R3 dc steady in idle", pin, 1); end
        rti = 0; tick();
        // R4 pulse with unchanged value
        tag = "R4";
        cls = 2; tick(); tick();
        chk("R4 before idle", pin, 1);
        rti = 1; tick(); chk("R4 inverse", pin, 0);
        tick(); chk("R4 return", pin, 1);
        tick(); chk("R4 rest", pin, 1);
        rti = 0; ubit = 0; upd = 1; tick(); upd = 0;
        rti = 1; tick(); chk("R4 inverse of 0", pin, 1);
        tick(); chk("R4 return to 0", pin, 0);
        rti = 0; tick();
        // R5 full train, test value 0 -> 1
        tag = "R5";
        cls = 3; ubit = 1; upd = 1; tick(); upd = 0; tick();
        rti = 1;
        tick(); chk("R5 t1", pin, 0);
        tick(); chk("R5 t2", pin, 1);
        tick(); chk("R5 t3", pin, 0);
        tick(); chk("R5 t4", pin, 1);
        tick(); chk("R5 hold", pin, 1);
        tick(); chk("R5 hold", pin, 1);
        // R6 early exit
        tag = "R6";
        rti = 0; tick();
        rti = 1; tick(); chk("R6 entry", pin, 0);
        rti = 0; tick(); chk("R6 settle", pin, 1);
        tick();
        // R7 latency in DC class
        tag = "R7";
        cls = 1; tick(); tick(); tick(); tick();
        raw = 1; tick(); tick();
        chk("R7 not yet", rxl, 0);
        tick(); chk("R7 arrived", rxl, 1);
        raw = 0; repeat (2) tick(); chk("R7 not yet fall", rxl, 1);
        tick(); chk("R7 fall", rxl, 0);
        // R8 AC receiver validation
        tag = "R8";
        cls = 2; repeat (4) tick();
        raw = 1; tick(); raw = 0; repeat (6) tick();
        chk("R8 1-sample glitch", rxl, 0);
        raw = 1; tick(); tick(); raw = 0; repeat (6) tick();
        chk("R8 2-sample glitch", rxl, 0);
        raw = 1; repeat (4) tick(); chk("R8 rise pending", rxl, 0);
        tick(); chk("R8 rise accepted", rxl, 1);
        raw = 0; repeat (4) tick(); chk("R8 fall pending", rxl, 1);
        tick(); chk("R8 fall accepted", rxl, 0);
        cls = 3; raw = 1; tick(); raw = 0; repeat (5) tick();
        chk("R8 train glitch kept", rxl, 0);
        repeat (3) tick();
        finish_run();
    end
endmodule